// File: doc/BRIEF.md
# Dual-Lane SIMD Load/Store Steering

This block sits between a single data memory port and a paired register file made of a primary bank and a secondary bank. Each cycle it takes one request (load, store, bank swap or idle) together with a register name, a bank selector, a base address, a post-modify step and three qualifiers: SIMD, broadcast and long-word. From these it produces the memory word addresses, the per-bank register write enables, the store data and the post-modified index. A memory model and both register banks are included, so the block can be exercised end to end.

A single request can feed both banks in four ways. A paired SIMD access moves two adjacent words, one per bank. A broadcast load copies one word into both banks. A long-word load fills two neighbouring registers of one bank. A swap exchanges a secondary register with a primary register. The SIMD mode bit is written through its own port and reaches the steering logic only after a pipeline delay.

Top module: `simd_ldst_steer`

## Requirements
- R1: After a synchronous active-high reset, every register of both banks reads 0, SIMD mode is off, and memory word i holds (i+1)*0x9E3779B1 truncated to 32 bits.
- R2: In SIMD mode, an ordinary load naming register n of bank B writes B[n] from word A and writes the other bank's register n from word A+1 (mod memory size). The second address is always A+1, whatever the post-modify value is.
- R3: In SIMD mode, an ordinary store naming n of bank B drives word A with B[n] and word A+1 with the other bank's register n. With SIMD off, only word A is written (st_we_hi low).
- R4: For every load or store, idx_out equals base+post_modify (mod memory size) and idx_vld is high in that same cycle. For swap and idle cycles, idx_vld stays low.
- R5: A broadcast load writes word A into both primary n and secondary n, with SIMD on or off.
- R6: A store with the broadcast flag set behaves exactly as the same store without the flag.
- R7: With SIMD off, an ordinary load writes only the named register. Naming a secondary register leaves the primary of the same index unchanged.
- R8: A long-word load naming n of bank B writes B[n] from word P and B[n+1 mod 16] from word P+1, where P is A with bit 0 cleared. It does this in either mode and leaves the other bank unchanged.
- R9: A swap (op code 2) exchanges secondary n with primary m, in either mode, and modifies no other register or memory word.
- R10: A mode write takes effect two cycles after it is presented. The access in the cycle right after the write still uses the previous mode.
- R11: If broadcast and long-word are both set on a load or store, long-word is ignored and err is high for that cycle only.
- R12: pri_we and sec_we show exactly the registers written at the coming clock edge, one bit per register index. Op codes are 0 load, 1 store, 2 swap and 3 idle. The bank selector is 1 for secondary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 swap, 3 idle |
| req_sec | input | 1 | Named register is in the secondary bank |
| req_reg | input | IW | Named register index (secondary index for swap) |
| req_xreg | input | IW | Primary index for swap |
| req_base | input | AW | Base word address |
| req_pmod | input | AW | Post-modify step |
| req_bcast | input | 1 | Broadcast qualifier |
| req_lword | input | 1 | Long-word qualifier |
| mode_wr | input | 1 | Write the SIMD mode bit |
| mode_val | input | 1 | New SIMD mode value |
| rd_sec | input | 1 | Inspection port bank select |
| rd_idx | input | IW | Inspection port register index |
| mem_addr_lo | output | AW | First word address |
| mem_addr_hi | output | AW | Second word address |
| st_we_lo | output | 1 | Store to first word |
| st_we_hi | output | 1 | Store to second word |
| st_data_lo | output | DW | Data for first word |
| st_data_hi | output | DW | Data for second word |
| pri_we | output | NREG | Primary bank write mask |
| sec_we | output | NREG | Secondary bank write mask |
| idx_out | output | AW | Post-modified index |
| idx_vld | output | 1 | idx_out valid |
| err | output | 1 | Broadcast and long-word conflict |
| rd_data | output | DW | Inspection port data |

## Verification
The bench builds the block with AW=5 (32 memory words), DW=32 and NREG=16. With these values every register index and every memory address can be swept in a few hundred cycles. Both wrap points can be hit directly: word 31 pairing with word 0, and long-word register 15 pairing with register 0. After each sweep, the contents of both banks are read back in full through the inspection port and compared with a model of the memory and the banks.

// File: rtl/sls_pkg.sv
package sls_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_SWAP  = 2'd2,
        OP_NOP   = 2'd3
    } sls_op_e;

    typedef enum logic [1:0] {
        SRC_LO  = 2'd0,
        SRC_HI  = 2'd1,
        SRC_XCH = 2'd2
    } sls_src_e;

    typedef struct packed {
        logic mode_stage;
        logic mode_on;
    } sls_mode_t;
endpackage

// File: rtl/sls_decode.sv
module sls_decode
    import sls_pkg::*;
#(
    parameter int unsigned AW = 5,
    parameter int unsigned IW = 4
) (
    input  logic          vld,
    input  sls_op_e       op,
    input  logic          sec,
    input  logic [IW-1:0] n,
    input  logic [IW-1:0] m,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pmod,
    input  logic          bcast,
    input  logic          lword,
    input  logic          simd,
    output logic [AW-1:0] addr_lo,
    output logic [AW-1:0] addr_hi,
    output logic [AW-1:0] idx_nxt,
    output logic          idx_vld,
    output logic          err,
    output logic [1:0]    en_a,
    output logic [1:0]    en_b,
    output logic [IW-1:0] ix_a [2],
    output logic [IW-1:0] ix_b [2],
    output sls_src_e      src_a [2],
    output sls_src_e      src_b [2],
    output logic          st_lo_en,
    output logic          st_hi_en,
    output logic          st_lo_bank,
    output logic          st_hi_bank,
    output logic [IW-1:0] st_lo_ix,
    output logic [IW-1:0] st_hi_ix
);
    logic access;
    logic use_bc;
    logic use_lw;
    logic nb;
    logic ob;

    always_comb begin
        access  = vld && (op == OP_LOAD || op == OP_STORE);
        use_bc  = bcast && (op == OP_LOAD);
        use_lw  = lword && !bcast;
        nb      = sec;
        ob      = !sec;
        addr_lo = use_lw ? {base[AW-1:1], 1'b0} : base;
        addr_hi = addr_lo + AW'(1);
        idx_nxt = base + pmod;
        idx_vld = access;
        err     = access && bcast && lword;

        en_a       = '0;
        en_b       = '0;
        st_lo_en   = 1'b0;
        st_hi_en   = 1'b0;
        st_lo_bank = nb;
        st_hi_bank = nb;
        st_lo_ix   = n;
        st_hi_ix   = n;
        for (int b = 0; b < 2; b++) begin
            ix_a[b]  = n;
            ix_b[b]  = n;
            src_a[b] = SRC_LO;
            src_b[b] = SRC_HI;
        end

        if (vld) begin
            case (op)
                OP_LOAD: begin
                    if (use_bc) begin
                        en_a = 2'b11;
                    end else if (use_lw) begin
                        en_a[nb] = 1'b1;
                        en_b[nb] = 1'b1;
                        ix_b[nb] = n + IW'(1);
                    end else if (simd) begin
                        en_a[nb]  = 1'b1;
                        en_a[ob]  = 1'b1;
                        src_a[ob] = SRC_HI;
                    end else begin
                        en_a[nb] = 1'b1;
                    end
                end
                OP_STORE: begin
                    st_lo_en = 1'b1;
                    if (use_lw) begin
                        st_hi_en = 1'b1;
                        st_hi_ix = n + IW'(1);
                    end else if (simd) begin
                        st_hi_en   = 1'b1;
                        st_hi_bank = ob;
                    end
                end
                OP_SWAP: begin
                    en_a     = 2'b11;
                    ix_a[0]  = m;
                    src_a[0] = SRC_XCH;
                    src_a[1] = SRC_XCH;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sls_bank.sv
module sls_bank #(
    parameter int unsigned NREG = 16,
    parameter int unsigned DW   = 32,
    parameter int unsigned IW   = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_a,
    input  logic [IW-1:0]            ix_a,
    input  logic [DW-1:0]            dat_a,
    input  logic                     en_b,
    input  logic [IW-1:0]            ix_b,
    input  logic [DW-1:0]            dat_b,
    output logic [NREG-1:0][DW-1:0]  q
);
    logic [NREG-1:0][DW-1:0] regs_d;
    logic [NREG-1:0][DW-1:0] regs_q;

    always_comb begin
        regs_d = regs_q;
        if (en_a) regs_d[ix_a] = dat_a;
        if (en_b) regs_d[ix_b] = dat_b;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign q = regs_q;

    // R8: the two write ports of a bank never target the same register
    a_r8_ports_distinct: assert property (@(posedge clk) disable iff (rst)
        (en_a && en_b) |-> (ix_a != ix_b));
endmodule

// File: rtl/sls_mem.sv
module sls_mem #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_lo,
    input  logic [AW-1:0] addr_hi,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [DW-1:0] wd_lo,
    input  logic [DW-1:0] wd_hi,
    output logic [DW-1:0] rd_lo,
    output logic [DW-1:0] rd_hi
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [DW-1:0] SEED = DW'(32'h9E3779B1);

    logic [DW-1:0] words_d [DEPTH];
    logic [DW-1:0] words_q [DEPTH];

    always_comb begin
        words_d = words_q;
        if (we_lo) words_d[addr_lo] = wd_lo;
        if (we_hi) words_d[addr_hi] = wd_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= DW'(i + 1) * SEED;
        end else begin
            words_q <= words_d;
        end
    end

    assign rd_lo = words_q[addr_lo];
    assign rd_hi = words_q[addr_hi];

    // R3: a paired store never writes one word from both lanes
    a_r3_lanes_apart: assert property (@(posedge clk) disable iff (rst)
        (we_lo && we_hi) |-> (addr_lo != addr_hi));
endmodule

// File: rtl/simd_ldst_steer.sv
module simd_ldst_steer
    import sls_pkg::*;
#(
    parameter int unsigned AW   = 5,
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic            req_sec,
    input  logic [IW-1:0]   req_reg,
    input  logic [IW-1:0]   req_xreg,
    input  logic [AW-1:0]   req_base,
    input  logic [AW-1:0]   req_pmod,
    input  logic            req_bcast,
    input  logic            req_lword,
    input  logic            mode_wr,
    input  logic            mode_val,
    input  logic            rd_sec,
    input  logic [IW-1:0]   rd_idx,
    output logic [AW-1:0]   mem_addr_lo,
    output logic [AW-1:0]   mem_addr_hi,
    output logic            st_we_lo,
    output logic            st_we_hi,
    output logic [DW-1:0]   st_data_lo,
    output logic [DW-1:0]   st_data_hi,
    output logic [NREG-1:0] pri_we,
    output logic [NREG-1:0] sec_we,
    output logic [AW-1:0]   idx_out,
    output logic            idx_vld,
    output logic            err,
    output logic [DW-1:0]   rd_data
);
    sls_mode_t mode_d;
    sls_mode_t mode_q;
    sls_op_e   op_e;

    logic [1:0]    en_a;
    logic [1:0]    en_b;
    logic [IW-1:0] ix_a [2];
    logic [IW-1:0] ix_b [2];
    sls_src_e      src_a [2];
    sls_src_e      src_b [2];
    logic          st_lo_bank;
    logic          st_hi_bank;
    logic [IW-1:0] st_lo_ix;
    logic [IW-1:0] st_hi_ix;
    logic [DW-1:0] rd_lo;
    logic [DW-1:0] rd_hi;
    logic [NREG-1:0][DW-1:0] bank_q [2];
    logic [NREG-1:0] we_mask [2];

    assign op_e = sls_op_e'(req_op);

    // mode bit passes a staging register before the steering logic sees it
    always_comb begin
        mode_d.mode_stage = mode_wr ? mode_val : mode_q.mode_stage;
        mode_d.mode_on    = mode_q.mode_stage;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_d;
    end

    sls_decode #(.AW(AW), .IW(IW)) u_dec (
        .vld        (req_valid),
        .op         (op_e),
        .sec        (req_sec),
        .n          (req_reg),
        .m          (req_xreg),
        .base       (req_base),
        .pmod       (req_pmod),
        .bcast      (req_bcast),
        .lword      (req_lword),
        .simd       (mode_q.mode_on),
        .addr_lo    (mem_addr_lo),
        .addr_hi    (mem_addr_hi),
        .idx_nxt    (idx_out),
        .idx_vld    (idx_vld),
        .err        (err),
        .en_a       (en_a),
        .en_b       (en_b),
        .ix_a       (ix_a),
        .ix_b       (ix_b),
        .src_a      (src_a),
        .src_b      (src_b),
        .st_lo_en   (st_we_lo),
        .st_hi_en   (st_we_hi),
        .st_lo_bank (st_lo_bank),
        .st_hi_bank (st_hi_bank),
        .st_lo_ix   (st_lo_ix),
        .st_hi_ix   (st_hi_ix)
    );

    assign st_data_lo = st_we_lo ? bank_q[st_lo_bank][st_lo_ix] : '0;
    assign st_data_hi = st_we_hi ? bank_q[st_hi_bank][st_hi_ix] : '0;

    sls_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .addr_lo (mem_addr_lo),
        .addr_hi (mem_addr_hi),
        .we_lo   (st_we_lo),
        .we_hi   (st_we_hi),
        .wd_lo   (st_data_lo),
        .wd_hi   (st_data_hi),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi)
    );

    for (genvar gb = 0; gb < 2; gb++) begin : g_bank
        logic [DW-1:0] xch;
        logic [DW-1:0] dat_a;
        logic [DW-1:0] dat_b;

        if (gb == 0) begin : g_pri
            assign xch = bank_q[1][req_reg];
        end else begin : g_sec
            assign xch = bank_q[0][req_xreg];
        end

        always_comb begin
            case (src_a[gb])
                SRC_LO:  dat_a = rd_lo;
                SRC_HI:  dat_a = rd_hi;
                default: dat_a = xch;
            endcase
            dat_b = (src_b[gb] == SRC_LO) ? rd_lo : rd_hi;
            we_mask[gb] = '0;
            if (en_a[gb]) we_mask[gb][ix_a[gb]] = 1'b1;
            if (en_b[gb]) we_mask[gb][ix_b[gb]] = 1'b1;
        end

        sls_bank #(.NREG(NREG), .DW(DW), .IW(IW)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .en_a  (en_a[gb]),
            .ix_a  (ix_a[gb]),
            .dat_a (dat_a),
            .en_b  (en_b[gb]),
            .ix_b  (ix_b[gb]),
            .dat_b (dat_b),
            .q     (bank_q[gb])
        );
    end

    assign pri_we  = we_mask[0];
    assign sec_we  = we_mask[1];
    assign rd_data = bank_q[rd_sec][rd_idx];

    // R10: the cycle after a mode write still runs with the earlier mode
    a_r10_mode_delay: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode_q.mode_on == $past(mode_q.mode_on)));

    // R11: the conflict flag only appears with both qualifiers present
    a_r11_err_cause: assert property (@(posedge clk) disable iff (rst)
        err |-> (req_bcast && req_lword && req_valid));

    // R5: broadcast load hits the same single index in both banks
    a_r5_bcast_both: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_e == OP_LOAD && req_bcast)
            |-> (pri_we == sec_we && $countones(pri_we) == 1));

    // R9: swap touches one register per bank and no memory
    a_r9_swap_single: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_e == OP_SWAP)
            |-> ($countones(pri_we) == 1 && $countones(sec_we) == 1 && !st_we_lo && !st_we_hi));

    // R4: index strobe only accompanies memory accesses
    a_r4_idx_only_access: assert property (@(posedge clk) disable iff (rst)
        idx_vld |-> (req_valid && (op_e == OP_LOAD || op_e == OP_STORE)));

    // R7: plain load outside SIMD mode writes exactly one register
    a_r7_plain_single: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_e == OP_LOAD && !req_bcast && !req_lword && !mode_q.mode_on)
            |-> ($countones({pri_we, sec_we}) == 1));

    // R8: secondary long-word load leaves the primary bank alone
    a_r8_lw_other_bank: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_e == OP_LOAD && req_lword && !req_bcast && req_sec)
            |-> (pri_we == '0 && $countones(sec_we) == 2));
endmodule

// File: tb/simd_ldst_steer_test.sv
`timescale 1ns/1ps
module simd_ldst_steer_test;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam int NR = 16;
    localparam int MD = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd3;
    logic req_sec = 1'b0;
    logic [3:0] req_reg = '0;
    logic [3:0] req_xreg = '0;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_pmod = '0;
    logic req_bcast = 1'b0;
    logic req_lword = 1'b0;
    logic mode_wr = 1'b0;
    logic mode_val = 1'b0;
    logic rd_sec = 1'b0;
    logic [3:0] rd_idx = '0;
    logic [AW-1:0] mem_addr_lo, mem_addr_hi, idx_out;
    logic st_we_lo, st_we_hi, idx_vld, err;
    logic [DW-1:0] st_data_lo, st_data_hi, rd_data;
    logic [NR-1:0] pri_we, sec_we;

    int nchk = 0;
    int nbad = 0;

    logic [31:0] bp [NR];
    logic [31:0] bs [NR];
    logic [31:0] bm [MD];
    bit mq = 0;
    bit stg = 0;

    simd_ldst_steer #(.AW(AW), .DW(DW), .NREG(NR)) uut (.*);

    always #2 clk = ~clk;

    initial begin
        #(4 * 150000);
        nbad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    function automatic logic [31:0] pat(int i);
        return 32'(i + 1) * 32'h9E3779B1;
    endfunction

    function automatic logic [31:0] rg(bit b, int i);
        return b ? bs[i] : bp[i];
    endfunction

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < NR; i++) begin
                rd_sec = b[0];
                rd_idx = 4'(i);
                #0.1;
                chk(rd_data == rg(b[0], i), $sformatf("%s bank%0d reg%0d", tag, b, i),
                    rd_data, rg(b[0], i));
            end
        end
    endtask

    task automatic step(int op, bit sec, int n, int x, int base, int pmod,
                        bit bc, bit lw, bit mw, bit mv, string tag);
        bit acc, ulw, ob, ehi;
        int lo, hi, n1;
        logic [NR-1:0] ep, es;
        logic [31:0] vlo, vhi, dlo, dhi, t;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_sec = sec; req_reg = 4'(n);
        req_xreg = 4'(x); req_base = AW'(base); req_pmod = AW'(pmod);
        req_bcast = bc; req_lword = lw; mode_wr = mw; mode_val = mv;
        #1;
        acc = (op < 2);
        ulw = lw && !bc;
        ob  = !sec;
        n1  = (n + 1) % NR;
        lo  = (acc && ulw) ? (base & (MD - 2)) : base;
        hi  = (lo + 1) % MD;
        ep = '0; es = '0; ehi = 0; dhi = '0;
        vlo = bm[lo]; vhi = bm[hi];
        dlo = rg(sec, n);
        if (op == 0) begin
            if (bc) begin ep[n] = 1; es[n] = 1; end
            else if (ulw) begin
                if (sec) begin es[n] = 1; es[n1] = 1; end else begin ep[n] = 1; ep[n1] = 1; end
            end else if (mq) begin ep[n] = 1; es[n] = 1; end
            else if (sec) es[n] = 1;
            else ep[n] = 1;
        end else if (op == 1) begin
            if (ulw) begin ehi = 1; dhi = rg(sec, n1); end
            else if (mq) begin ehi = 1; dhi = rg(ob, n); end
        end else if (op == 2) begin
            es[n] = 1; ep[x] = 1;
        end
        chk(idx_vld == acc, {tag, "/R4 idx_vld"}, 32'(idx_vld), 32'(acc));
        if (acc) begin
            chk(idx_out == AW'(base + pmod), {tag, "/R4 idx_out"}, 32'(idx_out), 32'((base + pmod) % MD));
            chk(mem_addr_lo == AW'(lo), {tag, "/R2 addr_lo"}, 32'(mem_addr_lo), 32'(lo));
            chk(mem_addr_hi == AW'(hi), {tag, "/R2 addr_hi"}, 32'(mem_addr_hi), 32'(hi));
        end
        chk(err == (acc && bc && lw), {tag, "/R11 err"}, 32'(err), 32'(acc && bc && lw));
        chk(pri_we == ep, {tag, "/R12 pri_we"}, 32'(pri_we), 32'(ep));
        chk(sec_we == es, {tag, "/R12 sec_we"}, 32'(sec_we), 32'(es));
        chk(st_we_lo == (op == 1), {tag, "/R3 st_we_lo"}, 32'(st_we_lo), 32'(op == 1));
        chk(st_we_hi == ehi, {tag, "/R3 st_we_hi"}, 32'(st_we_hi), 32'(ehi));
        if (op == 1) chk(st_data_lo == dlo, {tag, "/R3 st_data_lo"}, st_data_lo, dlo);
        if (ehi) chk(st_data_hi == dhi, {tag, "/R3 st_data_hi"}, st_data_hi, dhi);
        // model update
        if (op == 0) begin
            if (bc) begin bp[n] = vlo; bs[n] = vlo; end
            else if (ulw) begin
                if (sec) begin bs[n] = vlo; bs[n1] = vhi; end else begin bp[n] = vlo; bp[n1] = vhi; end
            end else if (mq) begin
                if (sec) begin bs[n] = vlo; bp[n] = vhi; end else begin bp[n] = vlo; bs[n] = vhi; end
            end else if (sec) bs[n] = vlo;
            else bp[n] = vlo;
        end else if (op == 1) begin
            bm[lo] = dlo;
            if (ehi) bm[hi] = dhi;
        end else if (op == 2) begin
            t = bs[n]; bs[n] = bp[x]; bp[x] = t;
        end
        @(posedge clk);
        mq = stg;
        if (mw) stg = mv;
        #1;
        req_valid = 1'b0; req_op = 2'd3; mode_wr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin bp[i] = '0; bs[i] = '0; end
        for (int i = 0; i < MD; i++) bm[i] = pat(i);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_all("R1 reset");
        // R1 memory pattern and R7 single-register loads, SIMD off
        for (int n = 0; n < NR; n++) step(0, 0, n, 0, n, 1, 0, 0, 0, 0, "R1");
        for (int n = 0; n < NR; n++) step(0, 1, n, 0, n + 16, 0, 0, 0, 0, 0, "R7");
        check_all("R7");
        // R9 swaps with differing indices
        for (int n = 0; n < NR; n++) step(2, 0, n, (n * 5 + 3) % NR, 0, 0, 0, 0, 0, 0, "R9");
        check_all("R9");
        // R10 mode write latency
        step(3, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R10");
        step(0, 0, 2, 0, 7, 3, 0, 0, 0, 0, "R10");
        step(0, 0, 4, 0, 9, 1, 0, 0, 0, 0, "R10");
        check_all("R10");
        // R2 paired loads, every base address including 31
        for (int a = 0; a < MD; a++) step(0, a[0], a % NR, 0, 31 - a, a, 0, 0, 0, 0, "R2");
        check_all("R2");
        // R3 paired stores, then R6 broadcast store in SIMD mode
        for (int a = 0; a < NR; a++) step(1, a[0], a, 0, 31 - 2 * a, 5, 0, 0, 0, 0, "R3");
        step(1, 0, 3, 0, 10, 1, 1, 0, 0, 0, "R6");
        for (int a = 0; a < NR; a++) step(0, 0, a, 0, 2 * a, 2, 0, 0, 0, 0, "R3");
        check_all("R3");
        // R5 broadcast loads, SIMD on then off
        for (int n = 0; n < 8; n++) step(0, n[0], n, 0, n * 4 + 1, 2, 1, 0, 0, 0, "R5");
        step(3, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R5");
        step(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        for (int n = 8; n < NR; n++) step(0, n[0], n, 0, n * 2 + 1, 2, 1, 0, 0, 0, "R5");
        check_all("R5");
        step(1, 1, 5, 0, 20, 0, 1, 0, 0, 0, "R6");
        step(0, 0, 6, 0, 20, 0, 0, 0, 0, 0, "R6");
        check_all("R6");
        // R8 long-word loads incl index 15 wrap and odd addresses
        for (int n = 0; n < NR; n++) step(0, 1, n, 0, (n * 3) % MD, 1, 0, 1, 0, 0, "R8");
        step(0, 0, 15, 0, 9, 1, 0, 1, 0, 0, "R8");
        step(3, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R8");
        step(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 1, 15, 0, 31, 1, 0, 1, 0, 0, "R8");
        step(1, 1, 7, 0, 13, 1, 0, 1, 0, 0, "R8");
        step(0, 0, 7, 0, 12, 1, 0, 1, 0, 0, "R8");
        check_all("R8");
        // R11 conflicting qualifiers
        step(0, 0, 6, 0, 13, 1, 1, 1, 0, 0, "R11");
        step(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 1, 2, 0, 13, 1, 1, 1, 0, 0, "R11");
        step(0, 1, 9, 0, 13, 1, 0, 0, 0, 0, "R11");
        check_all("R12 final");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule